// File: doc/BRIEF.md
# Data Memory Space Bus Controller

This block sits between a small processor core and a 16-bit byte-addressed data space. Each address belongs to one of four regions. Two are register banks (general registers and I/O registers), one is a 1 KiB on-chip SRAM, and one is an optional off-chip memory. The block holds the three on-chip regions in its own storage. It reports which region a request hits and returns read data from that region.

Off-chip accesses go out over a simple asynchronous-style bus with active-low read and write strobes. The core is stalled for the extra cycles each byte needs: one cycle normally, or two when the slow-device mode is on. A control input gates the off-chip region. When it is clear, addresses above the SRAM decode to nothing: reads return zero, writes are dropped and no stall is raised.

Top module: `dms_bus_ctrl`

## Requirements
- R1: An access to addresses 0 to 31 asserts only `sel_gpr`, and an access to addresses 32 to 95 asserts only `sel_io`. No stall is raised and both strobes stay high.
- R2: An access to addresses 96 to 1119 asserts only `sel_sram` and raises no stall.
- R3: An access to addresses 1120 to 65535 asserts `sel_ext` only while `ext_en` is 1.
- R4: An on-chip write takes one cycle. A later read of the same address returns the written byte in the same cycle as the request.
- R5: `ext_rd_n` and `ext_wr_n` stay at 1 in every cycle of an on-chip access.
- R6: With `ws_en` = 0, an off-chip access holds `stall` at 1 for exactly one cycle. The active strobe is then 0 for exactly one cycle, the cycle in which the access completes.
- R7: With `ws_en` = 1, an off-chip access holds `stall` at 1 for exactly two cycles, and the active strobe is 0 for exactly two cycles.
- R8: `ext_rd_n` is pulled low only for reads and `ext_wr_n` only for writes. The two are never low together, and both are back at 1 once the access has completed.
- R9: With `ext_en` = 0, an access above 1119 raises no stall and no select and returns 0 on reads. A write to it is dropped: both strobes stay high, and the off-chip byte at that address keeps its value.
- R10: While a strobe is low, `ext_addr` equals the request address and `ext_wdata` equals the write byte. `ext_addr` does not change between consecutive strobe cycles. In the completing cycle of an off-chip read, `rdata` equals `ext_rdata`.
- R11: While reset is active, `stall` is 0 and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Data-space byte address |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| wdata | input | 8 | Write byte |
| ext_en | input | 1 | Enables the off-chip region |
| ws_en | input | 1 | Adds a second extra cycle per off-chip byte |
| ext_rdata | input | 8 | Read byte from the off-chip device |
| rdata | output | 8 | Read byte returned to the core |
| stall | output | 1 | Core must hold its request for another cycle |
| sel_gpr | output | 1 | Request hits the general registers |
| sel_io | output | 1 | Request hits the I/O registers |
| sel_sram | output | 1 | Request hits the on-chip SRAM |
| sel_ext | output | 1 | Request hits the off-chip memory |
| ext_addr | output | 16 | Off-chip address |
| ext_wdata | output | 8 | Off-chip write byte |
| ext_rd_n | output | 1 | Off-chip read strobe, active low |
| ext_wr_n | output | 1 | Off-chip write strobe, active low |

## Verification
The assertions rely on three conditions at the core side. `rd` and `wr` are never high together. The core keeps `addr`, `wdata`, the request and both mode bits unchanged while `stall` is high and through the completing cycle. Requests are dropped for at least one cycle between accesses only when the core chooses to. The stimulus meets these conditions by driving each access from one task. That task sets all inputs on a falling edge, leaves them untouched until it sees `stall` low, and clears the request only after the completing rising edge. Addresses, data, direction and both mode bits are drawn at random from a fixed seed within these rules. Directed accesses to every region boundary are added.

// File: rtl/dms_pkg.sv
`timescale 1ns/1ps
package dms_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_GPR  = 3'd1,
    RG_IO   = 3'd2,
    RG_SRAM = 3'd3,
    RG_EXT  = 3'd4
  } region_e;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_XFER = 1'b1
  } xstate_e;

endpackage

// File: rtl/dms_rst_sync.sv
`timescale 1ns/1ps
module dms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dms_decode.sv
`timescale 1ns/1ps
module dms_decode
  import dms_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_en,
  output region_e           region
);

  localparam int IO_BASE   = GPR_N;
  localparam int SRAM_BASE = GPR_N + IO_N;
  localparam int EXT_BASE  = GPR_N + IO_N + SRAM_N;

  localparam logic [ADDR_W-1:0] IO_B   = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] SRAM_B = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] EXT_B  = ADDR_W'(EXT_BASE);

  always_comb begin
    if (addr < IO_B) begin
      region = RG_GPR;
    end else if (addr < SRAM_B) begin
      region = RG_IO;
    end else if (addr < EXT_B) begin
      region = RG_SRAM;
    end else if (ext_en) begin
      region = RG_EXT;
    end else begin
      region = RG_NONE;
    end
  end

  // R3
  always_comb begin
    ext_gate_chk: assert (!(region == RG_EXT && !ext_en) || $isunknown(addr));
  end

endmodule

// File: rtl/dms_store.sv
`timescale 1ns/1ps
module dms_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1120,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;

  always_comb begin
    in_range = (32'(idx) < DEPTH);
  end

  always_ff @(posedge clk) begin
    if (we && in_range) begin
      mem[idx] <= wdata;
    end
  end

  always_comb begin
    if (in_range) begin
      rdata = mem[idx];
    end else begin
      rdata = '0;
    end
  end

endmodule

// File: rtl/dms_ext_seq.sv
`timescale 1ns/1ps
module dms_ext_seq
  import dms_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BASE_EXTRA = 1,
  parameter int WAIT_EXTRA = 2,
  localparam int CNT_W     = $clog2(WAIT_EXTRA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic              ws_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              stall,
  output logic              busy,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);

  localparam logic [CNT_W-1:0] N_BASE = CNT_W'(BASE_EXTRA);
  localparam logic [CNT_W-1:0] N_WAIT = CNT_W'(WAIT_EXTRA);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  xstate_e           state_q, state_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              is_wr_q, is_wr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              go;
  logic              load_en;

  always_comb begin
    go      = go_rd || go_wr;
    load_en = (state_q == XS_IDLE) && go;
  end

  // next state
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    is_wr_d = is_wr_q;
    case (state_q)
      XS_IDLE: begin
        if (go) begin
          state_d = XS_XFER;
          rem_d   = ws_en ? N_WAIT : N_BASE;
          is_wr_d = go_wr;
        end
      end
      XS_XFER: begin
        if (rem_q <= ONE) begin
          state_d = XS_IDLE;
          rem_d   = '0;
        end else begin
          rem_d = rem_q - ONE;
        end
      end
      default: begin
        state_d = XS_IDLE;
        rem_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      rem_q   <= '0;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      is_wr_q <= is_wr_d;
    end
  end

  // address/data capture, clock enable written out, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_comb begin
    busy      = (state_q == XS_XFER);
    stall     = load_en || (busy && (rem_q > ONE));
    ext_addr  = busy ? addr_q : addr;
    ext_wdata = busy ? wdata_q : wdata;
    ext_rd_n  = !(busy && !is_wr_q);
    ext_wr_n  = !(busy && is_wr_q);
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  // R6
  go_enters_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_IDLE && go && !ws_en) |=> (busy && !stall));

  // R7
  wait_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_IDLE && go && ws_en) |=> (busy && stall) ##1 (busy && !stall));

  // R10
  xfer_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ext_addr) && $stable(ext_wdata)));

  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stall) |=> (!busy || $past(rem_q) == ONE) && (ext_rd_n && ext_wr_n || stall));

endmodule

// File: rtl/dms_bus_ctrl.sv
`timescale 1ns/1ps
module dms_bus_ctrl
  import dms_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int GPR_N      = 32,
  parameter int IO_N       = 64,
  parameter int SRAM_N     = 1024,
  parameter int BASE_EXTRA = 1,
  parameter int WAIT_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext_en,
  input  logic              ws_en,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              stall,
  output logic              sel_gpr,
  output logic              sel_io,
  output logic              sel_sram,
  output logic              sel_ext,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);

  localparam int INT_N = GPR_N + IO_N + SRAM_N;
  localparam int IDX_W = $clog2(INT_N);

  logic              rst_s_n;
  region_e           region;
  logic              req;
  logic              on_chip;
  logic              store_we;
  logic [DATA_W-1:0] store_rdata;
  logic              go_rd;
  logic              go_wr;
  logic              xbusy;

  dms_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  dms_decode #(
    .ADDR_W (ADDR_W),
    .GPR_N  (GPR_N),
    .IO_N   (IO_N),
    .SRAM_N (SRAM_N)
  ) u_decode (
    .addr   (addr),
    .ext_en (ext_en),
    .region (region)
  );

  always_comb begin
    req      = rst_s_n && (rd || wr);
    on_chip  = (region == RG_GPR) || (region == RG_IO) || (region == RG_SRAM);
    sel_gpr  = req && (region == RG_GPR);
    sel_io   = req && (region == RG_IO);
    sel_sram = req && (region == RG_SRAM);
    sel_ext  = req && (region == RG_EXT);
    store_we = rst_s_n && wr && on_chip;
    go_rd    = sel_ext && rd;
    go_wr    = sel_ext && wr;
  end

  dms_store #(
    .DATA_W (DATA_W),
    .DEPTH  (INT_N)
  ) u_store (
    .clk   (clk),
    .we    (store_we),
    .idx   (addr[IDX_W-1:0]),
    .wdata (wdata),
    .rdata (store_rdata)
  );

  dms_ext_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BASE_EXTRA (BASE_EXTRA),
    .WAIT_EXTRA (WAIT_EXTRA)
  ) u_ext_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .go_rd     (go_rd),
    .go_wr     (go_wr),
    .ws_en     (ws_en),
    .addr      (addr),
    .wdata     (wdata),
    .stall     (stall),
    .busy      (xbusy),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n)
  );

  always_comb begin
    if (sel_ext) begin
      rdata = ext_rdata;
    end else if (req && on_chip) begin
      rdata = store_rdata;
    end else begin
      rdata = '0;
    end
  end

  // R5
  onchip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((sel_gpr || sel_io || sel_sram) && !xbusy) |-> (ext_rd_n && ext_wr_n && !stall));

  // R9
  disabled_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req && !ext_en && !on_chip && !xbusy) |-> (!stall && rdata == '0));

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({sel_gpr, sel_io, sel_sram, sel_ext}));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |-> (!stall && ext_rd_n && ext_wr_n));

endmodule

// File: tb/test_dms_bus_ctrl.sv
`timescale 1ns/1ps
module test_dms_bus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        rd, wr;
  logic [7:0]  wdata;
  logic        ext_en, ws_en;
  logic [7:0]  ext_rdata;
  logic [7:0]  rdata;
  logic        stall, sel_gpr, sel_io, sel_sram, sel_ext;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_rd_n, ext_wr_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem_m [1120];
  logic [7:0] xdev  [4096];
  logic [7:0] ex_m  [4096];

  always #4 clk = ~clk;

  dms_bus_ctrl i_dms_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .ext_en(ext_en), .ws_en(ws_en), .ext_rdata(ext_rdata), .rdata(rdata),
    .stall(stall), .sel_gpr(sel_gpr), .sel_io(sel_io), .sel_sram(sel_sram),
    .sel_ext(sel_ext), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  // off-chip device model
  assign ext_rdata = xdev[ext_addr[11:0]];
  always @(posedge clk) begin
    if (!ext_wr_n) xdev[ext_addr[11:0]] <= ext_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int region_of(input logic [15:0] a, input bit xe);
    if (a < 16'd32) return 0;
    if (a < 16'd96) return 1;
    if (a < 16'd1120) return 2;
    return xe ? 3 : 4;
  endfunction

  task automatic do_op(input bit is_wr, input logic [15:0] a, input logic [7:0] d,
                       input bit xe, input bit ws);
    int st = 0, rs = 0, wsc = 0, cyc = 0;
    bit moved = 0, done = 0;
    logic [7:0] rv = 8'h00;
    logic [3:0] sels = 4'h0;
    logic [7:0] dev_at_end = 8'h00;
    int reg_k;
    int exp_st;
    logic [7:0] exp_rd;
    reg_k = region_of(a, xe);
    @(negedge clk);
    addr = a; rd = !is_wr; wr = is_wr; wdata = d; ext_en = xe; ws_en = ws;
    while (!done && cyc < 6) begin
      #1;
      cyc++;
      if (cyc == 1) sels = {sel_gpr, sel_io, sel_sram, sel_ext};
      if (stall) st++;
      if (!ext_rd_n) rs++;
      if (!ext_wr_n) wsc++;
      if ((!ext_rd_n || !ext_wr_n) &&
          (ext_addr !== a || (is_wr && ext_wdata !== d))) moved = 1;
      if (!stall) begin
        rv = rdata;
        dev_at_end = ext_rdata;
        done = 1;
      end
      @(negedge clk);
    end
    rd = 0; wr = 0;
    #1;
    // R8: strobes released after completion
    chk(ext_rd_n && ext_wr_n, "R8 strobes idle after access", {ext_rd_n, ext_wr_n}, 3);
    exp_st = (reg_k == 3) ? (ws ? 2 : 1) : 0;
    case (reg_k)
      0: chk(sels == 4'b1000, "R1 select gpr", sels, 4'b1000);
      1: chk(sels == 4'b0100, "R1 select io", sels, 4'b0100);
      2: chk(sels == 4'b0010, "R2 select sram", sels, 4'b0010);
      3: chk(sels == 4'b0001, "R3 select ext", sels, 4'b0001);
      default: chk(sels == 4'b0000, "R9 no select when disabled", sels, 0);
    endcase
    if (reg_k == 3) begin
      chk(st == exp_st, ws ? "R7 stall cycles" : "R6 stall cycles", st, exp_st);
      chk(is_wr ? (wsc == exp_st && rs == 0) : (rs == exp_st && wsc == 0),
          ws ? "R7 strobe cycles" : "R6 strobe cycles", is_wr ? wsc : rs, exp_st);
      chk(!moved, "R10 ext addr/data held", moved, 0);
      if (!is_wr) chk(rv === dev_at_end, "R10 rdata from device", rv, dev_at_end);
    end else begin
      chk(st == 0, (reg_k == 4) ? "R9 no stall" : "R4 no stall", st, 0);
      chk(rs == 0 && wsc == 0, (reg_k == 4) ? "R9 strobes idle" : "R5 strobes idle",
          rs + wsc, 0);
    end
    if (is_wr) begin
      if (reg_k <= 2) mem_m[a] = d;
      else if (reg_k == 3) ex_m[a[11:0]] = d;
    end else begin
      if (reg_k <= 2) exp_rd = mem_m[a];
      else if (reg_k == 3) exp_rd = ex_m[a[11:0]];
      else exp_rd = 8'h00;
      chk(rv === exp_rd, (reg_k == 4) ? "R9 read zero" :
                         (reg_k == 3) ? "R10 ext read data" : "R4 read back", rv, exp_rd);
    end
  endtask

  function automatic logic [15:0] rand_addr();
    case ($urandom % 5)
      0: return 16'($urandom % 32);
      1: return 16'(32 + $urandom % 64);
      2: return 16'(96 + $urandom % 1024);
      3: return 16'(1120 + $urandom % 200);
      default: return 16'(65535 - $urandom % 200);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      xdev[i] = 8'(i) ^ 8'h5A;
      ex_m[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 0; addr = 0; rd = 0; wr = 0; wdata = 0; ext_en = 0; ws_en = 0;
    repeat (3) @(negedge clk);
    // R11: reset state, even with a pending off-chip request
    addr = 16'd2000; rd = 1; ext_en = 1;
    #1;
    chk(!stall, "R11 stall low in reset", stall, 0);
    chk(ext_rd_n && ext_wr_n, "R11 strobes high in reset", {ext_rd_n, ext_wr_n}, 3);
    rd = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // fill on-chip space (R4)
    for (int i = 0; i < 1120; i++) do_op(1, 16'(i), 8'($urandom), 0, 0);

    // directed boundaries
    do_op(0, 16'd0, 0, 0, 0);
    do_op(0, 16'd31, 0, 0, 0);
    do_op(0, 16'd32, 0, 0, 0);
    do_op(0, 16'd95, 0, 0, 0);
    do_op(0, 16'd96, 0, 0, 0);
    do_op(0, 16'd1119, 0, 1, 1);
    do_op(1, 16'd1120, 8'hC3, 1, 0);
    do_op(0, 16'd1120, 0, 1, 0);
    do_op(1, 16'd65535, 8'h3C, 1, 1);
    do_op(0, 16'd65535, 0, 1, 1);
    // R9: disabled write dropped, then read with region enabled
    do_op(1, 16'd1120, 8'h99, 0, 0);
    do_op(0, 16'd1120, 0, 0, 1);
    do_op(0, 16'd1120, 0, 1, 0);
    // back-to-back off-chip accesses
    do_op(1, 16'd1200, 8'h11, 1, 1);
    do_op(0, 16'd1200, 0, 1, 0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      do_op(1'($urandom), rand_addr(), 8'($urandom), 1'($urandom % 4 != 0), 1'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule